// File: doc/BRIEF.md
# Link Port Framing and Status Controller

This block holds the control and status state of one point-to-point link port. Software programs a small configuration word. It sets the local request and response credit size codes, which go into outgoing idle flits. It also sets a retry-disable bit, a port enable and two interrupt enables. The receiver hands the block one decoded flit per strobe, with a good-CRC flag, an idle-flit flag, an acknowledgment bit and the peer's two credit size codes.

While the port is enabled, the block counts consecutive good idle flits. When the run reaches a parameterised threshold, it declares the port framed. It captures the peer's credit codes and the acknowledgment from every good idle flit. It decodes all size codes into credit counts. It raises a level interrupt when framing completes and when the presence input changes, provided the matching enable is set. Clearing the port enable drops the sync output and restarts initialization, which clears all framing status.

Top module: `link_port_ctl`

## Requirements
- R1: A 3-bit size code c decodes to the credit count 2^c for c from 0 to 4, and to 25 for codes 5, 6 and 7. This applies to the local and to the peer codes.
- R2: The configuration word has this layout: [2:0] local request size, [5:3] local response size, [6] retry disable, [7] port enable, [8] framing interrupt enable, [9] presence interrupt enable. Reset sets both sizes to 5 and every other field to 0. A write loads all fields. cfg_rdata_o[9:0] reads the word back, and tx_req_sz_o and tx_rsp_sz_o present the two local size codes.
- R3: The peer request size (cfg_rdata_o[12:10]) and the peer response size (cfg_rdata_o[15:13]) reset to 0. They load from every strobed flit that has a good CRC and is an idle flit while the port is enabled. Any other flit leaves them unchanged.
- R4: Idle-detected (cfg_rdata_o[17]) sets on the FRAME_CNT-th consecutive good idle flit. Cycles without a strobe do not break the run.
- R5: Before detection, a strobed flit that has a bad CRC or is not an idle flit restarts the run from zero.
- R6: Ack-detected (cfg_rdata_o[16]) sets on a good idle flit that carries the acknowledgment bit. It stays set until the next initialization.
- R7: While the port enable is 0, sync_o is low and idle-detected, ack-detected and the run count are all held clear.
- R8: llr_en_o is high only when the port is framed, the port is enabled and retry disable is 0. link_up_o is high only when the port is framed, enabled and present.
- R9: With the framing interrupt enable set, the cycle in which idle-detected goes from 0 to 1 makes irq_o high.
- R10: The presence input passes through two flops, and cfg_rdata_o[18] shows the synchronized value. With the presence interrupt enable set, either edge of that value makes irq_o high.
- R11: While the synchronized presence is low, drv_en_o is low and abort_o is high.
- R12: Each interrupt request stays pending until its enable is cleared. Clearing an enable drops that request, and irq_o is the OR of the pending requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_wdata_i | input | 10 | Configuration write data |
| cfg_rdata_o | output | 19 | Configuration and status readback |
| flit_stb_i | input | 1 | A received flit is presented |
| flit_ok_i | input | 1 | Flit passed its CRC check |
| flit_idle_i | input | 1 | Flit is an idle flit |
| flit_ack_i | input | 1 | Acknowledgment bit of the idle flit |
| flit_req_sz_i | input | 3 | Peer request credit size code |
| flit_rsp_sz_i | input | 3 | Peer response credit size code |
| pres_i | input | 1 | Asynchronous port presence |
| sync_o | output | 1 | Sync output, low during reset of the link |
| llr_en_o | output | 1 | Link level retry enable |
| link_up_o | output | 1 | Port framed, enabled and present |
| drv_en_o | output | 1 | Port output drivers enable |
| abort_o | output | 1 | Transactions to the port are aborted |
| irq_o | output | 1 | Level interrupt request |
| tx_req_sz_o | output | 3 | Local request size code for idle flits |
| tx_rsp_sz_o | output | 3 | Local response size code for idle flits |
| tx_req_credits_o | output | 5 | Decoded local request credits |
| tx_rsp_credits_o | output | 5 | Decoded local response credits |
| peer_req_credits_o | output | 5 | Decoded peer request credits |
| peer_rsp_credits_o | output | 5 | Decoded peer response credits |

## Verification
The hardest state to reach is a run that stops exactly one flit short of the threshold after a break. The bench drives a run of good idle flits, breaks it with a non-idle flit and then with a bad-CRC flit, and follows each break with FRAME_CNT-1 good flits. It confirms that detection stays clear at that point and sets on the next flit. A second hard case is the pending interrupt around an enable change. The bench clears the enable after framing and after a presence edge, and checks that irq_o falls. It then re-arms the enable and flips presence in the opposite direction to show that both edges raise irq_o.

// File: rtl/link_port_pkg.sv
package link_port_pkg;
  localparam int SZ_W   = 3;
  localparam int CRED_W = 5;
  localparam int CFG_W  = 10;
  localparam int RD_W   = CFG_W + 2 * SZ_W + 3;
  localparam logic [SZ_W-1:0]   SZ_RST   = 3'd5;
  localparam logic [SZ_W-1:0]   SZ_SAT   = 3'd5;
  localparam logic [CRED_W-1:0] CRED_MAX = 5'd25;

  typedef struct packed {
    logic            ie_pres;
    logic            ie_frame;
    logic            port_en;
    logic            retry_dis;
    logic [SZ_W-1:0] rsp_sz;
    logic [SZ_W-1:0] req_sz;
  } cfg_t;

  localparam cfg_t CFG_RST = '{ie_pres: 1'b0, ie_frame: 1'b0, port_en: 1'b0,
                               retry_dis: 1'b0, rsp_sz: SZ_RST, req_sz: SZ_RST};

  function automatic logic [CRED_W-1:0] size_to_credits(input logic [SZ_W-1:0] code);
    if (code >= SZ_SAT) return CRED_MAX;
    return {{(CRED_W-1){1'b0}}, 1'b1} << code;
  endfunction
endpackage

// File: rtl/link_port_framer.sv
module link_port_framer
  import link_port_pkg::*;
#(
  parameter int FRAME_CNT = 256
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            en_i,
  input  logic            stb_i,
  input  logic            ok_i,
  input  logic            idle_i,
  input  logic            ack_i,
  input  logic [SZ_W-1:0] req_sz_i,
  input  logic [SZ_W-1:0] rsp_sz_i,
  output logic            det_o,
  output logic            det_set_o,
  output logic            ack_o,
  output logic [SZ_W-1:0] peer_req_o,
  output logic [SZ_W-1:0] peer_rsp_o
);
  localparam int CW = $clog2(FRAME_CNT + 1);
  localparam logic [CW-1:0] LAST = CW'(FRAME_CNT - 1);
  localparam logic [CW-1:0] FULL = CW'(FRAME_CNT);

  logic [CW-1:0] cnt_q;
  logic          good;

  assign good      = stb_i & ok_i & idle_i;
  assign det_set_o = en_i & ~det_o & good & (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q      <= '0;
      det_o      <= 1'b0;
      ack_o      <= 1'b0;
      peer_req_o <= '0;
      peer_rsp_o <= '0;
    end else if (!en_i) begin
      // initialization: status restarts
      cnt_q <= '0;
      det_o <= 1'b0;
      ack_o <= 1'b0;
    end else begin
      if (good) begin
        peer_req_o <= req_sz_i;
        peer_rsp_o <= rsp_sz_i;
        if (ack_i) ack_o <= 1'b1;
      end
      if (!det_o) begin
        if (good) begin
          if (cnt_q == LAST) begin
            det_o <= 1'b1;
            cnt_q <= FULL;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end else if (stb_i) begin
          cnt_q <= '0;
        end
      end
    end
  end

  a_r3_peer_capture: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && good |=> peer_req_o == $past(req_sz_i) && peer_rsp_o == $past(rsp_sz_i));
  a_r4_detect_on_good: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(det_o) |-> $past(good));
  a_r5_break_restarts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && !det_o && stb_i && !good |=> cnt_q == '0);
  a_r6_ack_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && ack_o |=> ack_o);
  a_r7_init_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !det_o && !ack_o && cnt_q == '0);
endmodule

// File: rtl/link_port_pres.sv
module link_port_pres (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pres_i,
  output logic pres_o,
  output logic chg_o
);
  logic s1_q, s2_q, s3_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
      s3_q <= 1'b0;
    end else begin
      s1_q <= pres_i;
      s2_q <= s1_q;
      s3_q <= s2_q;
    end
  end

  assign pres_o = s2_q;
  assign chg_o  = s2_q ^ s3_q;

  a_r10_sync_delay: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(pres_i, 2) |-> !pres_o);
endmodule

// File: rtl/link_port_irq.sv
module link_port_irq (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ie_frame_i,
  input  logic ie_pres_i,
  input  logic frame_set_i,
  input  logic pres_chg_i,
  output logic irq_o
);
  logic pend_frame_q, pend_pres_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_frame_q <= 1'b0;
      pend_pres_q  <= 1'b0;
    end else begin
      pend_frame_q <= ie_frame_i & (pend_frame_q | frame_set_i);
      pend_pres_q  <= ie_pres_i  & (pend_pres_q  | pres_chg_i);
    end
  end

  assign irq_o = pend_frame_q | pend_pres_q;

  a_r9_frame_irq: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ie_frame_i && frame_set_i |=> irq_o);
  a_r10_pres_irq: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ie_pres_i && pres_chg_i |=> irq_o);
  a_r12_enable_drop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ie_frame_i && !ie_pres_i |=> !irq_o);
endmodule

// File: rtl/link_port_ctl.sv
module link_port_ctl
  import link_port_pkg::*;
#(
  parameter int FRAME_CNT = 256
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [CFG_W-1:0]  cfg_wdata_i,
  output logic [RD_W-1:0]   cfg_rdata_o,
  input  logic              flit_stb_i,
  input  logic              flit_ok_i,
  input  logic              flit_idle_i,
  input  logic              flit_ack_i,
  input  logic [SZ_W-1:0]   flit_req_sz_i,
  input  logic [SZ_W-1:0]   flit_rsp_sz_i,
  input  logic              pres_i,
  output logic              sync_o,
  output logic              llr_en_o,
  output logic              link_up_o,
  output logic              drv_en_o,
  output logic              abort_o,
  output logic              irq_o,
  output logic [SZ_W-1:0]   tx_req_sz_o,
  output logic [SZ_W-1:0]   tx_rsp_sz_o,
  output logic [CRED_W-1:0] tx_req_credits_o,
  output logic [CRED_W-1:0] tx_rsp_credits_o,
  output logic [CRED_W-1:0] peer_req_credits_o,
  output logic [CRED_W-1:0] peer_rsp_credits_o
);
  localparam int NDEC = 4;

  cfg_t            cfg_q;
  logic            det, det_set, ack_det, pres_s, pres_chg;
  logic [SZ_W-1:0] peer_req, peer_rsp;
  logic [NDEC-1:0][SZ_W-1:0]   dec_in;
  logic [NDEC-1:0][CRED_W-1:0] dec_out;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cfg_q <= CFG_RST;
    else if (cfg_we_i) cfg_q <= cfg_t'(cfg_wdata_i);
  end

  link_port_framer #(.FRAME_CNT(FRAME_CNT)) i_framer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (cfg_q.port_en),
    .stb_i      (flit_stb_i),
    .ok_i       (flit_ok_i),
    .idle_i     (flit_idle_i),
    .ack_i      (flit_ack_i),
    .req_sz_i   (flit_req_sz_i),
    .rsp_sz_i   (flit_rsp_sz_i),
    .det_o      (det),
    .det_set_o  (det_set),
    .ack_o      (ack_det),
    .peer_req_o (peer_req),
    .peer_rsp_o (peer_rsp)
  );

  link_port_pres i_pres (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pres_i (pres_i),
    .pres_o (pres_s),
    .chg_o  (pres_chg)
  );

  link_port_irq i_irq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .ie_frame_i  (cfg_q.ie_frame),
    .ie_pres_i   (cfg_q.ie_pres),
    .frame_set_i (det_set),
    .pres_chg_i  (pres_chg),
    .irq_o       (irq_o)
  );

  assign dec_in = {peer_rsp, peer_req, cfg_q.rsp_sz, cfg_q.req_sz};

  for (genvar g = 0; g < NDEC; g++) begin : g_dec
    assign dec_out[g] = size_to_credits(dec_in[g]);
  end

  assign tx_req_credits_o   = dec_out[0];
  assign tx_rsp_credits_o   = dec_out[1];
  assign peer_req_credits_o = dec_out[2];
  assign peer_rsp_credits_o = dec_out[3];

  assign tx_req_sz_o = cfg_q.req_sz;
  assign tx_rsp_sz_o = cfg_q.rsp_sz;
  assign sync_o      = cfg_q.port_en;
  // retry stays off until framing is complete
  assign llr_en_o    = det & cfg_q.port_en & ~cfg_q.retry_dis;
  assign link_up_o   = det & cfg_q.port_en & pres_s;
  assign drv_en_o    = cfg_q.port_en & pres_s;
  assign abort_o     = ~pres_s;
  assign cfg_rdata_o = {pres_s, det, ack_det, peer_rsp, peer_req, cfg_q};

  a_r1_credit_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_req_credits_o == CRED_MAX || $countones(tx_req_credits_o) == 1) &&
    (peer_req_credits_o == CRED_MAX || $countones(peer_req_credits_o) == 1));
  a_r2_cfg_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_we_i |=> tx_req_sz_o == $past(cfg_wdata_i[2:0]) && tx_rsp_sz_o == $past(cfg_wdata_i[5:3]));
  a_r8_llr_framed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    llr_en_o |-> cfg_rdata_o[17] && sync_o);
  a_r11_absent: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(pres_i, 2) |-> !drv_en_o && abort_o && !link_up_o);
endmodule

// File: tb/test_link_port_ctl.sv
module test_link_port_ctl;
  localparam int CLK_PERIOD = 10;
  localparam int FRAME = 256;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [9:0]  cfg_wdata = '0;
  logic [18:0] rdata;
  logic        stb = 1'b0, ok = 1'b0, idle = 1'b0, ack = 1'b0;
  logic [2:0]  rq = '0, rs = '0;
  logic        pres = 1'b1;
  logic        sync, llr_en, link_up, drv_en, abort_s, irq;
  logic [2:0]  tx_rq, tx_rs;
  logic [4:0]  tx_rq_c, tx_rs_c, pr_rq_c, pr_rs_c;
  int          n_chk = 0, n_fail = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  link_port_ctl #(.FRAME_CNT(FRAME)) i_link_port_ctl (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(cfg_we), .cfg_wdata_i(cfg_wdata),
    .cfg_rdata_o(rdata), .flit_stb_i(stb), .flit_ok_i(ok), .flit_idle_i(idle),
    .flit_ack_i(ack), .flit_req_sz_i(rq), .flit_rsp_sz_i(rs), .pres_i(pres),
    .sync_o(sync), .llr_en_o(llr_en), .link_up_o(link_up), .drv_en_o(drv_en),
    .abort_o(abort_s), .irq_o(irq), .tx_req_sz_o(tx_rq), .tx_rsp_sz_o(tx_rs),
    .tx_req_credits_o(tx_rq_c), .tx_rsp_credits_o(tx_rs_c),
    .peer_req_credits_o(pr_rq_c), .peer_rsp_credits_o(pr_rs_c)
  );

  // {code, expected credits}
  localparam logic [7:0] DEC_VEC [8] = '{
    {3'd0, 5'd1}, {3'd1, 5'd2}, {3'd2, 5'd4}, {3'd3, 5'd8},
    {3'd4, 5'd16}, {3'd5, 5'd25}, {3'd6, 5'd25}, {3'd7, 5'd25}};

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [9:0] cfg(input logic iep, ief, en, rdis,
                                     input logic [2:0] rsp, req);
    return {iep, ief, en, rdis, rsp, req};
  endfunction

  task automatic wr(input logic [9:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic flit(input logic f_ok, f_idle, f_ack, input logic [2:0] f_rq, f_rs);
    @(negedge clk);
    stb = 1'b1; ok = f_ok; idle = f_idle; ack = f_ack; rq = f_rq; rs = f_rs;
    @(negedge clk);
    stb = 1'b0;
  endtask

  task automatic finish_run;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // reset state
    chk("R2 reset cfg", int'(rdata[9:0]), int'(cfg(0, 0, 0, 0, 3'd5, 3'd5)));
    chk("R3 reset peer", int'(rdata[15:10]), 0);
    chk("R4 reset det", int'(rdata[17:16]), 0);
    chk("R7 reset sync", int'(sync), 0);
    chk("R1 reset tx credits", int'(tx_rq_c), 25);
    chk("R12 reset irq", int'(irq), 0);
    chk("R10 presence synced", int'(rdata[18]), 1);

    // R1 decode table; response code mirrors the request code
    for (int i = 0; i < 8; i++) begin
      wr(cfg(0, 0, 0, 0, DEC_VEC[7-i][7:5], DEC_VEC[i][7:5]));
      chk("R1 req decode", int'(tx_rq_c), int'(DEC_VEC[i][4:0]));
      chk("R1 rsp decode", int'(tx_rs_c), int'(DEC_VEC[7-i][4:0]));
      chk("R2 tx size", int'(tx_rq), int'(DEC_VEC[i][7:5]));
    end

    // framing with interrupt enabled
    wr(cfg(0, 1, 1, 0, 3'd5, 3'd5));
    chk("R7 sync high", int'(sync), 1);
    repeat (FRAME - 1) flit(1, 1, 0, 3'd3, 3'd2);
    chk("R4 short run", int'(rdata[17]), 0);
    chk("R8 llr off framing", int'(llr_en), 0);
    chk("R3 peer req", int'(pr_rq_c), 8);
    chk("R3 peer rsp", int'(pr_rs_c), 4);
    flit(1, 1, 0, 3'd3, 3'd2);
    chk("R4 detected", int'(rdata[17]), 1);
    chk("R9 frame irq", int'(irq), 1);
    chk("R8 llr on", int'(llr_en), 1);
    chk("R8 link up", int'(link_up), 1);
    flit(1, 0, 1, 3'd7, 3'd7);
    chk("R3 non-idle ignored", int'(rdata[15:10]), int'({3'd2, 3'd3}));
    chk("R6 ack on non-idle", int'(rdata[16]), 0);
    flit(1, 1, 1, 3'd6, 3'd1);
    chk("R6 ack detected", int'(rdata[16]), 1);
    chk("R3 peer update", int'(pr_rq_c), 25);
    flit(1, 1, 0, 3'd6, 3'd1);
    chk("R6 ack sticky", int'(rdata[16]), 1);
    wr(cfg(0, 0, 1, 0, 3'd5, 3'd5));
    @(negedge clk);
    chk("R12 frame irq dropped", int'(irq), 0);
    chk("R12 status kept", int'(rdata[17]), 1);

    // disable restarts initialization
    wr(cfg(0, 0, 0, 1, 3'd5, 3'd5));
    @(negedge clk);
    chk("R7 sync low", int'(sync), 0);
    chk("R7 status cleared", int'(rdata[17:16]), 0);
    chk("R11 drivers off", int'(drv_en), 0);
    wr(cfg(0, 1, 1, 1, 3'd5, 3'd5));
    repeat (100) flit(1, 1, 0, 3'd1, 3'd1);
    flit(1, 0, 0, 3'd1, 3'd1);
    repeat (FRAME - 1) flit(1, 1, 0, 3'd1, 3'd1);
    chk("R5 non-idle break", int'(rdata[17]), 0);
    flit(0, 1, 0, 3'd4, 3'd4);
    chk("R3 bad crc ignored", int'(pr_rq_c), 2);
    repeat (FRAME - 1) flit(1, 1, 0, 3'd1, 3'd1);
    chk("R5 bad crc break", int'(rdata[17]), 0);
    chk("R12 no irq yet", int'(irq), 0);
    flit(1, 1, 0, 3'd1, 3'd1);
    chk("R5 detect after break", int'(rdata[17]), 1);
    chk("R9 irq after break", int'(irq), 1);
    chk("R8 retry disabled", int'(llr_en), 0);

    // presence edges
    wr(cfg(1, 0, 1, 0, 3'd5, 3'd5));
    @(negedge clk);
    chk("R12 irq cleared", int'(irq), 0);
    pres = 1'b0;
    repeat (4) @(negedge clk);
    chk("R10 falling irq", int'(irq), 1);
    chk("R10 synced low", int'(rdata[18]), 0);
    chk("R11 drv off", int'(drv_en), 0);
    chk("R11 abort", int'(abort_s), 1);
    chk("R8 link down", int'(link_up), 0);
    wr(cfg(0, 0, 1, 0, 3'd5, 3'd5));
    @(negedge clk);
    chk("R12 pres irq dropped", int'(irq), 0);
    wr(cfg(1, 0, 1, 0, 3'd5, 3'd5));
    @(negedge clk);
    chk("R12 no stale irq", int'(irq), 0);
    pres = 1'b1;
    repeat (4) @(negedge clk);
    chk("R10 rising irq", int'(irq), 1);
    chk("R11 drv on", int'(drv_en), 1);
    chk("R11 abort off", int'(abort_s), 0);
    finish_run();
  end
endmodule